// File: doc/BRIEF.md
# Dual-Channel Integration Timer

This block runs two integrating conversions side by side from a free-running oscillator clock. The integration window length is chosen by a 2-bit select. Three codes pick fixed windows that are whole multiples of a 918-clock unit. The fourth code hands the window to a run bit that opens and closes it. Each channel has a count-request input that stands in for the analog front end. A request is accepted only if the previous clock took no count on that channel, so a channel can gain at most one count every two clocks.

At the close of a window, each channel's count has a fixed offset of two removed, floored at zero and clamped to the largest value of the result width. Both results then load together into output registers, and a one-clock end-of-conversion strobe fires. In the timed modes the next window starts on the following clock. A gain bit chooses between two settings. In high gain, every accepted request is one count. In low gain, each channel takes sixteen accepted requests to make one count. While the power input is low, nothing counts and all window state is cleared, but the last results stay on the outputs.

Top module: `dual_integ_timer`

## Requirements
- R1: After reset, both results read 0 and `eoc` is low.
- R2: With `pwr_on` high and `integ_sel` at 0, 1 or 2, a window lasts 11, 81 or 322 units of `UNIT_CLKS` clocks (default 918). The first window starts on the first clock with `pwr_on` high, and each later window starts on the clock right after the previous one ended.
- R3: A channel accepts a request only if it accepted none on the previous clock. A request held high for an N-clock window (N even) gives N/2 accepted requests.
- R4: A result is the channel's count minus 2, and is 0 when the count is 2 or less.
- R5: A result saturates at 2^DATA_W−1 (65535 by default) and never wraps.
- R6: Both results are replaced on the same clock, and only when a window ends. At every other time they hold their values.
- R7: `eoc` is high for exactly one clock, in the same cycle that the new results first appear.
- R8: With `gain_hi`=1, every accepted request adds one count. With `gain_hi`=0, a count is added on every sixteenth accepted request in the window. The setting applies to both channels.
- R9: With `integ_sel`=3, the window is open while `manual_run` is 1. The results load on the clock after `manual_run` falls, and no `eoc` occurs while `manual_run` stays at either level.
- R10: While `pwr_on` is low, there is no counting and no `eoc`, and the results hold. After power returns, a fresh window starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | 1 = integrate, 0 = powered down |
| integ_sel | input | 2 | Window select: 0/1/2 timed, 3 manual |
| manual_run | input | 1 | Manual window open while 1 |
| gain_hi | input | 1 | 1 = high gain, 0 = low gain (1/16) |
| cnt_req | input | 2 | Per-channel count request (bit 0 = channel 0) |
| ch0_result | output | DATA_W | Channel 0 result register |
| ch1_result | output | DATA_W | Channel 1 result register |
| eoc | output | 1 | One-clock end-of-conversion strobe |

## Verification
The hardest case to reach from the ports is the clamp at full scale, because it needs the longest window and a channel requesting on every clock. The bench reaches it by shrinking the unit length and the result width through parameters, so the longest timed window overflows quickly. The boundary between a window's last clock and the next window's first clock is also hard to observe directly. The bench pins it down by driving requests at clock offsets counted from power-up, then checking that the results are still unchanged one clock before the expected end and updated exactly at the end.

// File: rtl/dit_pkg.sv
package dit_pkg;
  typedef enum logic [1:0] {
    SEL_SHORT  = 2'd0,
    SEL_MID    = 2'd1,
    SEL_LONG   = 2'd2,
    SEL_MANUAL = 2'd3
  } integ_sel_e;
endpackage

// File: rtl/dit_window.sv
module dit_window #(
  parameter int UNIT_CLKS = 918,
  parameter int MULT_S    = 11,
  parameter int MULT_M    = 81,
  parameter int MULT_L    = 322
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on,
  input  logic [1:0] integ_sel,
  input  logic       manual_run,
  output logic       win_active,
  output logic       win_end,
  output logic       win_clear
);
  import dit_pkg::*;

  localparam int TW = $clog2(MULT_L * UNIT_CLKS + 1);
  localparam logic [TW-1:0] LEN_S = TW'(MULT_S * UNIT_CLKS);
  localparam logic [TW-1:0] LEN_M = TW'(MULT_M * UNIT_CLKS);
  localparam logic [TW-1:0] LEN_L = TW'(MULT_L * UNIT_CLKS);

  logic [TW-1:0] tcnt_q, tcnt_d, limit;
  logic          man_q, man_d;
  logic          is_man;

  always_comb begin
    is_man = (integ_sel == SEL_MANUAL);
    case (integ_sel)
      SEL_SHORT: limit = LEN_S;
      SEL_MID:   limit = LEN_M;
      default:   limit = LEN_L;
    endcase
    win_active = pwr_on & (~is_man | manual_run);
    win_end    = pwr_on & (is_man ? (man_q & ~manual_run)
                                  : (tcnt_q >= limit - TW'(1)));
    win_clear  = ~pwr_on | (is_man & ~manual_run);
    if (~pwr_on | is_man | win_end) tcnt_d = '0;
    else                            tcnt_d = tcnt_q + TW'(1);
    man_d = pwr_on & is_man & manual_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      man_q  <= 1'b0;
    end else begin
      tcnt_q <= tcnt_d;
      man_q  <= man_d;
    end
  end
endmodule

// File: rtl/dit_channel.sv
module dit_channel #(
  parameter int DATA_W     = 16,
  parameter int OFFSET     = 2,
  parameter int GAIN_RATIO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              restart,
  input  logic              gain_hi,
  input  logic              req,
  output logic [DATA_W-1:0] conv_val
);
  localparam int RAW_W = DATA_W + 1;
  localparam int PRE_W = $clog2(GAIN_RATIO);
  localparam logic [RAW_W-1:0] RAW_CAP = RAW_W'((2 ** DATA_W) - 1 + OFFSET);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(GAIN_RATIO - 1);

  logic [RAW_W-1:0] raw_q, raw_d, raw_inc;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             cool_q, cool_d;
  logic             take, tick;

  always_comb begin
    take    = active & req & ~cool_q;
    tick    = gain_hi ? take : (take & (pre_q == PRE_TOP));
    raw_inc = (tick && raw_q != RAW_CAP) ? raw_q + RAW_W'(1) : raw_q;
    if (raw_inc <= RAW_W'(OFFSET)) conv_val = '0;
    else                           conv_val = DATA_W'(raw_inc - RAW_W'(OFFSET));
    raw_d  = restart ? '0 : raw_inc;
    pre_d  = restart ? '0 : (take ? pre_q + PRE_W'(1) : pre_q);
    cool_d = restart ? 1'b0 : take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pre_q  <= '0;
      cool_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      pre_q  <= pre_d;
      cool_q <= cool_d;
    end
  end
endmodule

// File: rtl/dual_integ_timer.sv
module dual_integ_timer #(
  parameter int UNIT_CLKS = 918,
  parameter int DATA_W    = 16,
  parameter int OFFSET    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic [1:0]        integ_sel,
  input  logic              manual_run,
  input  logic              gain_hi,
  input  logic [1:0]        cnt_req,
  output logic [DATA_W-1:0] ch0_result,
  output logic [DATA_W-1:0] ch1_result,
  output logic              eoc
);
  localparam int N_CH = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              win_active, win_end, win_clear, restart;
  logic [DATA_W-1:0] conv  [N_CH];
  logic [DATA_W-1:0] res_q [N_CH];
  logic [DATA_W-1:0] res_d [N_CH];
  logic              eoc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dit_window #(.UNIT_CLKS(UNIT_CLKS)) u_win (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pwr_on     (pwr_on),
    .integ_sel  (integ_sel),
    .manual_run (manual_run),
    .win_active (win_active),
    .win_end    (win_end),
    .win_clear  (win_clear)
  );

  assign restart = win_end | win_clear;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dit_channel #(.DATA_W(DATA_W), .OFFSET(OFFSET)) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .active   (win_active),
      .restart  (restart),
      .gain_hi  (gain_hi),
      .req      (cnt_req[c]),
      .conv_val (conv[c])
    );
    assign res_d[c] = win_end ? conv[c] : res_q[c];
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) res_q[c] <= '0;
      else            res_q[c] <= res_d[c];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) eoc_q <= 1'b0;
    else            eoc_q <= win_end;
  end

  assign ch0_result = res_q[0];
  assign ch1_result = res_q[1];
  assign eoc        = eoc_q;
endmodule

// File: rtl/dit_chk.sv
module dit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_on,
  input logic [1:0]        integ_sel,
  input logic              manual_run,
  input logic [DATA_W-1:0] ch0_result,
  input logic [DATA_W-1:0] ch1_result,
  input logic              eoc
);
  p_hold_ch0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(ch0_result));
  p_hold_ch1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(ch1_result));
  p_eoc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !eoc);
  p_manual_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_sel == 2'd3 && manual_run) |=> !eoc);
endmodule

bind dual_integ_timer dit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_on     (pwr_on),
  .integ_sel  (integ_sel),
  .manual_run (manual_run),
  .ch0_result (ch0_result),
  .ch1_result (ch1_result),
  .eoc        (eoc)
);

// File: tb/sim_dual_integ_timer.sv
module sim_dual_integ_timer;
  localparam int UNIT = 20;
  localparam int DW   = 10;
  localparam int MAXV = (1 << DW) - 1;

  typedef struct packed {
    logic [1:0] sel;
    logic       hi;
    logic [3:0] p0;
    logic [3:0] p1;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b1, 4'd1, 4'd1},
    '{2'd0, 1'b1, 4'd3, 4'd0},
    '{2'd1, 1'b1, 4'd1, 4'd5},
    '{2'd2, 1'b1, 4'd1, 4'd2},
    '{2'd1, 1'b0, 4'd1, 4'd7},
    '{2'd0, 1'b1, 4'd4, 4'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n, pwr_on, manual_run, gain_hi;
  logic [1:0]    integ_sel, cnt_req;
  logic [DW-1:0] ch0_result, ch1_result;
  logic          eoc;
  int            n_chk = 0, n_bad = 0, eoc_seen = 0;

  always #5 clk = ~clk;

  dual_integ_timer #(.UNIT_CLKS(UNIT), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .integ_sel(integ_sel),
    .manual_run(manual_run), .gain_hi(gain_hi), .cnt_req(cnt_req),
    .ch0_result(ch0_result), .ch1_result(ch1_result), .eoc(eoc)
  );

  always @(posedge clk) if (eoc) eoc_seen++;

  function automatic int win_len(input int sel);
    if (sel == 0) return 11 * UNIT;
    if (sel == 1) return 81 * UNIT;
    return 322 * UNIT;
  endfunction

  // requests on clocks k with k % p == 0; p==1 means held high
  function automatic int expect_val(input int n, input int p, input bit hi);
    int acc;
    if (p == 0)      acc = 0;
    else if (p == 1) acc = n / 2;
    else             acc = (n + p - 1) / p;
    if (!hi) acc = acc / 16;
    acc = acc - 2;
    if (acc < 0) acc = 0;
    if (acc > MAXV) acc = MAXV;
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; clock k of the window is the k-th following posedge
  task automatic run_window(input int n, input int p0, input int p1,
                            input int e0, input int e1, input string tag);
    int old0, old1;
    old0 = ch0_result;
    old1 = ch1_result;
    for (int k = 0; k < n; k++) begin
      cnt_req[0] = (p0 != 0) && (k % p0 == 0);
      cnt_req[1] = (p1 != 0) && (k % p1 == 0);
      @(negedge clk);
      if (k == n - 2) begin
        check(eoc == 1'b0, {tag, " R2 no eoc before end"}, eoc, 0);
        check(ch0_result == old0, {tag, " R6 ch0 held"}, ch0_result, old0);
        check(ch1_result == old1, {tag, " R6 ch1 held"}, ch1_result, old1);
      end
    end
    cnt_req = 2'b00;
    check(eoc == 1'b1, {tag, " R7 eoc at end"}, eoc, 1);
    check(ch0_result == e0, {tag, " ch0 result"}, ch0_result, e0);
    check(ch1_result == e1, {tag, " ch1 result"}, ch1_result, e1);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seen;
    rst_n = 1'b0; pwr_on = 1'b0; manual_run = 1'b0; gain_hi = 1'b1;
    integ_sel = 2'd0; cnt_req = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(eoc == 1'b0, "R1 eoc after reset", eoc, 0);
    check(ch0_result == 0, "R1 ch0 after reset", ch0_result, 0);
    check(ch1_result == 0, "R1 ch1 after reset", ch1_result, 0);

    // table walk: R2 R3 R4 R5 R8
    foreach (VECS[i]) begin
      int n;
      pwr_on = 1'b0;
      repeat (2) @(negedge clk);
      integ_sel = VECS[i].sel;
      gain_hi   = VECS[i].hi;
      pwr_on    = 1'b1;
      n = win_len(VECS[i].sel);
      run_window(n, VECS[i].p0, VECS[i].p1,
                 expect_val(n, VECS[i].p0, VECS[i].hi),
                 expect_val(n, VECS[i].p1, VECS[i].hi),
                 $sformatf("vec%0d R3 R4 R5 R8", i));
    end

    // automatic restart, back-to-back windows (R2)
    pwr_on = 1'b0;
    repeat (2) @(negedge clk);
    integ_sel = 2'd0; gain_hi = 1'b1; pwr_on = 1'b1;
    run_window(220, 3, 0, 72, 0, "R2 first window");
    run_window(220, 2, 1, 108, 108, "R2 restarted window");
    @(negedge clk);
    check(eoc == 1'b0, "R7 eoc one clock", eoc, 0);

    // power down with requests held: nothing happens (R10)
    pwr_on = 1'b0; cnt_req = 2'b11;
    seen = eoc_seen;
    repeat (500) @(negedge clk);
    check(eoc_seen == seen, "R10 no eoc while off", eoc_seen, seen);
    check(ch0_result == 108, "R10 ch0 held while off", ch0_result, 108);
    check(ch1_result == 108, "R10 ch1 held while off", ch1_result, 108);
    cnt_req = 2'b00;
    pwr_on = 1'b1;
    run_window(220, 4, 0, 53, 0, "R10 fresh window after power-up");

    // manual mode (R9)
    pwr_on = 1'b0;
    @(negedge clk);
    integ_sel = 2'd3; manual_run = 1'b0; pwr_on = 1'b1; cnt_req = 2'b11;
    seen = eoc_seen;
    repeat (3000) @(negedge clk);
    check(eoc_seen == seen, "R9 no eoc with run low", eoc_seen, seen);
    manual_run = 1'b1;
    for (int k = 0; k < 300; k++) begin
      cnt_req[0] = 1'b1;
      cnt_req[1] = (k % 3 == 0);
      @(negedge clk);
    end
    check(eoc_seen == seen, "R9 no eoc with run high", eoc_seen, seen);
    manual_run = 1'b0; cnt_req = 2'b00;
    @(negedge clk);
    check(eoc == 1'b1, "R9 eoc after run falls", eoc, 1);
    check(ch0_result == 148, "R9 manual ch0", ch0_result, 148);
    check(ch1_result == 98, "R9 manual ch1", ch1_result, 98);
    @(negedge clk);
    check(eoc == 1'b0, "R7 manual eoc one clock", eoc, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule